// File: doc/BRIEF.md
# Three-Stage Neural Dot-Product Pipeline

This block is a small fixed-point datapath for neural-network layers. Each output lane computes the dot product of a shared row of input activations with its own row of synaptic weights. The datapath has three pipeline stages: a parallel multiplier array, an adder-tree reduction that also adds a stored running sum, and a saturating rectifier. Activations, weights and results live in three separate on-chip buffers. The activation and weight buffers are filled through a load port. Results are read back through a combinational read port.

Work is driven only by commands on a valid/ready port. Each command names an activation row, a weight row and a result row, and carries two flags. The *first* flag starts the sum from zero. Without it, the sum continues from the value already held in the result row. The *last* flag applies saturation and rectification to the sum. Without it, the raw 32-bit running sum is written back. A layer wider than one pass is therefore computed as a chain of commands that target the same result row. The controller accepts one command per cycle, except when a command would read a result row that an earlier command has not yet written. In that case it holds the command off.

Top module: `neuro_pipe3`

## Requirements
- R1: After reset, `done` is low and `cmd_ready` is high while no command is offered.
- R2: Lane l of a result equals the sum over i of act[i]·wt[l][i]. Activation i sits in bits [16i+15:16i] of the activation row. Weight (l,i) sits in bits [16(4l+i)+15:16(4l+i)] of the weight row. All operands are signed 16-bit.
- R3: When `cmd_first` is 1, the stored value of the result row is ignored and the sum starts from zero.
- R4: When `cmd_first` is 0, the stored lane value is added to the new dot product. When `cmd_last` is 0, the raw 32-bit sum is stored in bits [32l+31:32l] of the result row.
- R5: When `cmd_last` is 1, each lane sum is clamped to [-32768, 32767], negative values become 0, and the result is stored zero-extended to 32 bits.
- R6: A command with `cmd_first`=0 is held off (`cmd_ready` low) while either of the two commands accepted in the previous two cycles targets the same result row. A dependent command therefore issues 3 cycles after the command it depends on.
- R7: A command with `cmd_first`=1, or one whose result row is not pending, is accepted in the cycle it is offered, so back-to-back issue runs at one command per cycle.
- R8: After a command with `cmd_last`=1 is accepted, `done` is high for one cycle, sampled at the 4th rising edge after the accepting edge. The result is readable on `rd_data` in that same cycle.
- R9: A load with `ld_sel`=0 writes `ld_data[63:0]` into activation row `ld_addr`. A load with `ld_sel`=1 writes all of `ld_data` into weight row `ld_addr`.
- R10: Accumulation wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Buffer load strobe |
| ld_sel | input | 1 | 0 = activation buffer, 1 = weight buffer |
| ld_addr | input | 4 | Row to load |
| ld_data | input | 256 | Row data (activation rows use the low 64 bits) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with valid |
| cmd_in_addr | input | 4 | Activation row |
| cmd_wt_addr | input | 4 | Weight row |
| cmd_out_addr | input | 3 | Result row |
| cmd_first | input | 1 | Start from zero |
| cmd_last | input | 1 | Clamp, rectify and finish |
| rd_addr | input | 3 | Result row to read |
| rd_data | output | 128 | Four 32-bit lane values of that row |
| done | output | 1 | Final result of a last-pass command written |

## Verification
The bench aims at the read-after-write window between dependent passes. A controller that issued too early would fold a stale partial sum into the result, and one that stalled too long would show a gap other than three cycles. It checks the first flag on a row that already holds data, where a design that kept the old sum would add it in. It drives sums past both 16-bit limits and a sum of exactly 2^32. A wrong clamp or rectifier order would give a negative or wrapped final value, and a non-wrapping accumulator would leave the raw sum nonzero. It also measures the `done` latency edge by edge.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
   typedef enum logic {
      LD_ACT = 1'b0,
      LD_WT  = 1'b1
   } ld_sel_e;
endpackage

// File: rtl/nfp_mul.sv
// Stage 1: one signed multiplier per (lane, input) pair, registered.
module nfp_mul #(
   parameter int LANES = 4,
   parameter int NIN   = 4,
   parameter int DW    = 16,
   localparam int PW   = 2 * DW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_v,
   input  logic [NIN*DW-1:0]         in_row,
   input  logic [LANES*NIN*DW-1:0]   wt_row,
   output logic                      out_v,
   output logic [LANES*NIN*PW-1:0]   prod
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_v <= 1'b0;
      else        out_v <= in_v;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar i = 0; i < NIN; i++) begin : g_in
         localparam int K = l * NIN + i;
         always_ff @(posedge clk) begin
            if (in_v)
               prod[K*PW +: PW] <= $signed(in_row[i*DW +: DW]) * $signed(wt_row[K*DW +: DW]);
         end
      end
   end
endmodule

// File: rtl/nfp_reduce.sv
// Stage 2: per-lane binary adder tree plus the stored running sum.
module nfp_reduce #(
   parameter int LANES = 4,
   parameter int NIN   = 4,
   parameter int DW    = 16,
   parameter int AW    = 32,
   localparam int PW   = 2 * DW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_v,
   input  logic                      first,
   input  logic [LANES*NIN*PW-1:0]   prod,
   input  logic [LANES*AW-1:0]       partial,
   output logic                      out_v,
   output logic [LANES*AW-1:0]       acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_v <= 1'b0;
      else        out_v <= in_v;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // heap-ordered tree: node 1 is the root, leaves are NIN .. 2*NIN-1
      logic signed [AW-1:0] node [1:2*NIN-1];
      logic signed [AW-1:0] base;

      for (genvar j = 0; j < NIN; j++) begin : g_leaf
         logic signed [PW-1:0] p;
         assign p = prod[(l*NIN+j)*PW +: PW];
         assign node[NIN+j] = AW'(p);
      end
      for (genvar n = NIN - 1; n >= 1; n--) begin : g_node
         assign node[n] = node[2*n] + node[2*n+1];
      end

      assign base = first ? '0 : $signed(partial[l*AW +: AW]);

      always_ff @(posedge clk) begin
         if (in_v) acc[l*AW +: AW] <= base + node[1];
      end
   end
endmodule

// File: rtl/nfp_act.sv
// Stage 3: on final passes clamp to DW bits and optionally rectify.
module nfp_act #(
   parameter int LANES  = 4,
   parameter int DW     = 16,
   parameter int AW     = 32,
   parameter bit RELU_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_v,
   input  logic                 last,
   input  logic [LANES*AW-1:0]  acc,
   output logic                 out_v,
   output logic [LANES*AW-1:0]  res
);
   localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_v <= 1'b0;
      else        out_v <= in_v;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [AW-1:0] sum, clamped, fin;
      assign sum = $signed(acc[l*AW +: AW]);

      always_comb begin
         if (sum > SMAX)      clamped = SMAX;
         else if (sum < SMIN) clamped = SMIN;
         else                 clamped = sum;
      end

      if (RELU_EN) begin : g_relu
         assign fin = clamped[AW-1] ? '0 : clamped;
      end else begin : g_lin
         assign fin = clamped;
      end

      always_ff @(posedge clk) begin
         if (in_v) res[l*AW +: AW] <= last ? fin : sum;
      end
   end
endmodule

// File: rtl/neuro_pipe3.sv
module neuro_pipe3
   import nfp_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int NIN     = 4,
   parameter int DW      = 16,
   parameter int AW      = 32,
   parameter int IDEPTH  = 16,
   parameter int WDEPTH  = 16,
   parameter int ODEPTH  = 8,
   parameter bit RELU_EN = 1'b1,
   localparam int IAW = (IDEPTH > 1) ? $clog2(IDEPTH) : 1,
   localparam int WAW = (WDEPTH > 1) ? $clog2(WDEPTH) : 1,
   localparam int OAW = (ODEPTH > 1) ? $clog2(ODEPTH) : 1,
   localparam int LAW = (IAW > WAW) ? IAW : WAW,
   localparam int IW  = NIN * DW,
   localparam int WW  = LANES * NIN * DW,
   localparam int OW  = LANES * AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_valid,
   input  logic            ld_sel,
   input  logic [LAW-1:0]  ld_addr,
   input  logic [WW-1:0]   ld_data,
   input  logic            cmd_valid,
   output logic            cmd_ready,
   input  logic [IAW-1:0]  cmd_in_addr,
   input  logic [WAW-1:0]  cmd_wt_addr,
   input  logic [OAW-1:0]  cmd_out_addr,
   input  logic            cmd_first,
   input  logic            cmd_last,
   input  logic [OAW-1:0]  rd_addr,
   output logic [OW-1:0]   rd_data,
   output logic            done
);
   localparam int PW = 2 * DW;

   // elaboration-time parameter checks
   if (LANES < 1 || NIN < 1) begin : g_chk_size
      $error("LANES and NIN must be at least 1");
   end
   if ((NIN & (NIN - 1)) != 0) begin : g_chk_tree
      $error("NIN must be a power of two for the adder tree");
   end
   if (AW < PW) begin : g_chk_acc
      $error("AW must hold a full product");
   end
   if ((IDEPTH & (IDEPTH-1)) != 0 || (WDEPTH & (WDEPTH-1)) != 0 || (ODEPTH & (ODEPTH-1)) != 0) begin : g_chk_depth
      $error("buffer depths must be powers of two");
   end

   // buffers
   logic [IW-1:0] act_buf [IDEPTH];
   logic [WW-1:0] wt_buf  [WDEPTH];
   logic [OW-1:0] res_buf [ODEPTH];

   always_ff @(posedge clk) begin
      if (ld_valid && ld_sel_e'(ld_sel) == LD_ACT)
         act_buf[ld_addr[IAW-1:0]] <= ld_data[IW-1:0];
      if (ld_valid && ld_sel_e'(ld_sel) == LD_WT)
         wt_buf[ld_addr[WAW-1:0]] <= ld_data;
   end

   // stage control
   logic            s1_v, s2_v, s3_v;
   logic [OAW-1:0]  s1_addr, s2_addr, s3_addr;
   logic            s1_first, s1_last, s2_last, s3_last;
   logic            hazard, issue;
   logic [LANES*NIN*PW-1:0] prod;
   logic [OW-1:0]   s2_acc, act_out;

   assign hazard = cmd_valid && !cmd_first &&
                   ((s1_v && s1_addr == cmd_out_addr) || (s2_v && s2_addr == cmd_out_addr));
   assign cmd_ready = !hazard;
   assign issue     = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_addr <= '0; s1_first <= 1'b0; s1_last <= 1'b0;
         s2_addr <= '0; s2_last  <= 1'b0;
         s3_addr <= '0; s3_last  <= 1'b0;
         done    <= 1'b0;
      end else begin
         if (issue) begin
            s1_addr  <= cmd_out_addr;
            s1_first <= cmd_first;
            s1_last  <= cmd_last;
         end
         if (s1_v) begin
            s2_addr <= s1_addr;
            s2_last <= s1_last;
         end
         if (s2_v) begin
            s3_addr <= s2_addr;
            s3_last <= s2_last;
         end
         done <= s3_v && s3_last;
      end
   end

   always_ff @(posedge clk) begin
      if (s3_v) res_buf[s3_addr] <= act_out;
   end

   assign rd_data = res_buf[rd_addr];

   nfp_mul #(.LANES(LANES), .NIN(NIN), .DW(DW)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (issue),
      .in_row (act_buf[cmd_in_addr]),
      .wt_row (wt_buf[cmd_wt_addr]),
      .out_v  (s1_v),
      .prod   (prod)
   );

   nfp_reduce #(.LANES(LANES), .NIN(NIN), .DW(DW), .AW(AW)) u_red (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (s1_v),
      .first   (s1_first),
      .prod    (prod),
      .partial (res_buf[s1_addr]),
      .out_v   (s2_v),
      .acc     (s2_acc)
   );

   nfp_act #(.LANES(LANES), .DW(DW), .AW(AW), .RELU_EN(RELU_EN)) u_act (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (s2_v),
      .last  (s2_last),
      .acc   (s2_acc),
      .out_v (s3_v),
      .res   (act_out)
   );
endmodule

// File: rtl/neuro_pipe3_chk.sv
module neuro_pipe3_chk #(
   parameter int OAW   = 3,
   parameter int LANES = 4,
   parameter int AW    = 32,
   parameter int DW    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic               cmd_first,
   input logic               cmd_last,
   input logic [OAW-1:0]     cmd_out_addr,
   input logic               done,
   input logic               wb_v,
   input logic               wb_last,
   input logic [LANES*AW-1:0] wb_data
);
   logic acc_cmd;
   assign acc_cmd = cmd_valid && cmd_ready;

   AST_FIRST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_first) |-> cmd_ready); // R7

   AST_DEP_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_cmd && !cmd_first) |-> !($past(acc_cmd) && $past(cmd_out_addr) == cmd_out_addr)); // R6

   AST_DEP_GAP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_cmd && !cmd_first) |-> !($past(acc_cmd, 2) && $past(cmd_out_addr, 2) == cmd_out_addr)); // R6

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(acc_cmd && cmd_last, 4)); // R8

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      AST_FINAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (wb_v && wb_last) |-> (wb_data[l*AW +: AW] < (AW'(1) << (DW-1)))); // R5
   end
endmodule

bind neuro_pipe3 neuro_pipe3_chk #(.OAW(OAW), .LANES(LANES), .AW(AW), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .cmd_first    (cmd_first),
   .cmd_last     (cmd_last),
   .cmd_out_addr (cmd_out_addr),
   .done         (done),
   .wb_v         (s3_v),
   .wb_last      (s3_last),
   .wb_data      (act_out)
);

// File: tb/neuro_pipe3_tb.sv
module neuro_pipe3_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_valid = 1'b0, ld_sel = 1'b0;
   logic [3:0]   ld_addr = '0;
   logic [255:0] ld_data = '0;
   logic         cmd_valid = 1'b0, cmd_first = 1'b0, cmd_last = 1'b0;
   logic         cmd_ready, done;
   logic [3:0]   cmd_in_addr = '0, cmd_wt_addr = '0;
   logic [2:0]   cmd_out_addr = '0, rd_addr = '0;
   logic [127:0] rd_data;

   int n_chk = 0, n_fail = 0;
   logic [63:0]        m_act [16];
   logic [255:0]       m_wt  [16];
   logic signed [31:0] m_res [8][4];

   always #5 clk = ~clk;

   neuro_pipe3 u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic signed [31:0] dot(input int l, input logic [63:0] a, input logic [255:0] w);
      logic signed [31:0] s = 0;
      for (int i = 0; i < 4; i++) begin
         logic signed [31:0] pa, pw;
         pa = 32'($signed(a[i*16 +: 16]));
         pw = 32'($signed(w[(l*4+i)*16 +: 16]));
         s = s + pa * pw;
      end
      return s;
   endfunction

   function automatic logic signed [31:0] finish_val(input logic signed [31:0] s);
      if (s > 32767) return 32767;
      if (s < 0)     return 0;
      return s;
   endfunction

   function automatic logic [15:0] rnd16();
      int r = $urandom_range(0, 9);
      if (r == 0) return 16'h8000;
      if (r == 1) return 16'h7fff;
      return 16'($urandom);
   endfunction

   task automatic load(input logic sel, input int addr, input logic [255:0] d);
      ld_valid = 1'b1; ld_sel = sel; ld_addr = 4'(addr); ld_data = d;
      if (sel) m_wt[addr] = d; else m_act[addr] = d[63:0];
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   // called at a negedge; returns at the negedge after the accepting edge, valid still high
   task automatic issue(input int ia, input int wa, input int oa, input bit f, input bit la,
                        output int stalls);
      cmd_valid = 1'b1; cmd_in_addr = 4'(ia); cmd_wt_addr = 4'(wa);
      cmd_out_addr = 3'(oa); cmd_first = f; cmd_last = la;
      stalls = 0;
      #1;
      while (!cmd_ready) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      for (int l = 0; l < 4; l++) begin
         logic signed [31:0] s;
         s = (f ? 32'sd0 : m_res[oa][l]) + dot(l, m_act[ia], m_wt[wa]);
         m_res[oa][l] = la ? finish_val(s) : s;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      cmd_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic check_row(input string req, input int oa);
      rd_addr = 3'(oa);
      #1;
      for (int l = 0; l < 4; l++) chk(req, rd_data[l*32 +: 32], m_res[oa][l]);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      int st;
      logic [255:0] w;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 done", 32'(done), 0);
      chk("R1 ready", 32'(cmd_ready), 1);

      // R9/R2/R5: saturation high, rectify low, in-range, zero
      load(1'b0, 0, {192'd0, {4{16'h7fff}}});
      w = '0;
      for (int i = 0; i < 4; i++) begin
         w[(0*4+i)*16 +: 16] = 16'h4000;
         w[(1*4+i)*16 +: 16] = 16'hc000;
         w[(2*4+i)*16 +: 16] = 16'h0001;
      end
      load(1'b1, 0, w);
      issue(0, 0, 0, 1, 1, st);
      cmd_valid = 1'b0;
      // R8: done at the 4th edge counting the accepting one
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk("R8 done timing", 32'(done), (k == 3) ? 1 : 0);
         if (k == 3) check_row("R5 R2 final clamp/rectify", 0);
      end
      chk("R5 lane0 clamp", rd_data[31:0], 32'd32767);
      chk("R5 lane1 rectify", rd_data[63:32], 32'd0);

      // R10: wrap of 4 * 2^30
      load(1'b0, 1, {192'd0, {4{16'h8000}}});
      load(1'b1, 1, {16{16'h8000}});
      issue(1, 1, 1, 1, 0, st);
      idle(4);
      check_row("R10 wrap", 1);
      chk("R10 lane0 zero", rd_data[31:0], 32'd0);

      // R6/R4: dependent pair stalls two cycles
      load(1'b0, 2, {192'd0, 16'd3, 16'hfffe, 16'd7, 16'd5});
      load(1'b1, 2, {16{16'd9}} ^ {8{32'h0001_fff0}});
      issue(2, 2, 2, 1, 0, st);
      chk("R7 first issue no stall", 32'(st), 0);
      issue(2, 2, 2, 0, 0, st);
      chk("R6 dependent stall cycles", 32'(st), 2);
      idle(4);
      check_row("R4 raw partial", 2);

      // R3: first flag overrides a populated row, issued back to back
      issue(0, 2, 3, 1, 0, st);
      issue(2, 2, 3, 1, 0, st);
      chk("R7 back-to-back first", 32'(st), 0);
      issue(1, 0, 4, 1, 0, st);
      issue(2, 1, 5, 1, 0, st);
      chk("R7 independent rows", 32'(st), 0);
      idle(4);
      check_row("R3 first clears", 3);
      check_row("R7 row4", 4);
      check_row("R7 row5", 5);

      // randomized multi-pass traffic
      for (int a = 0; a < 16; a++) begin
         logic [255:0] d = '0;
         for (int k = 0; k < 16; k++) d[k*16 +: 16] = rnd16();
         load(1'b0, a, d);
         load(1'b1, a, d ^ {8{32'($urandom)}});
      end
      for (int o = 0; o < 8; o++) issue($urandom_range(0, 15), $urandom_range(0, 15), o, 1, 0, st);
      for (int n = 0; n < 120; n++) begin
         issue($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7),
               $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0, st);
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      idle(5);
      for (int o = 0; o < 8; o++) check_row("R2 R4 R5 random passes", o);
      summary();
   end
endmodule